// File: doc/BRIEF.md
# GCR 6-and-2 Sector Data Field Encoder

The encoder turns one sector's payload into the byte stream a disk serializer writes for the data field. It fetches 12 tag bytes and then 512 data bytes through a byte-request port, one index at a time in ascending order. The whole payload is first preceded by a self-synchronizing sync run and the data-field prefix. Bytes are taken in groups of three and whitened by three chained running checksums. Each group is split 6-and-2 into four 6-bit symbols, and every symbol is mapped to a disk byte that is legal on the medium. The three checksums, a four-byte trailer and a write-underrun verdict from the serializer close the field.

Every output byte is offered with `wr_valid` and moves only when the serializer raises `wr_ready`. A single `start` pulse launches a field. `done` pulses once the trailer has gone out, and `wr_err` then shows whether the serializer reported an underrun.

The controller is one state machine with these states:
- `ST_IDLE`: waiting for `start`.
- `ST_SYNC`: the nine prefix bytes.
- `ST_FETCH`: issues one source read.
- `ST_LOAD`: captures the byte and advances the checksums.
- `ST_GROUP`: the four symbols of a group, or fewer for the short final group.
- `ST_CKSUM`: the checksum symbols.
- `ST_TRAIL`: the trailer.
- `ST_FINISH`: samples the underrun status.

The transitions are:
- `start` moves IDLE to SYNC.
- The ninth accepted prefix byte moves SYNC to FETCH.
- FETCH always moves to LOAD.
- LOAD goes back to FETCH while the group still lacks bytes, and otherwise moves to GROUP.
- The last accepted group symbol moves GROUP to FETCH while payload remains, and otherwise to CKSUM.
- The fourth accepted checksum symbol moves CKSUM to TRAIL.
- The fourth accepted trailer byte moves TRAIL to FINISH.
- FINISH always returns to IDLE.

Top module: `gcr_sector_encoder`

## Requirements
- R1: After reset, and at any time while idle, `wr_valid`, `src_rd` and `done` are 0.
- R2: A field opens with the nine bytes FF 3F CF F3 FC FF D5 AA AD, where AD is the disk code of symbol 0x0B.
- R3: A byte transfers only in a cycle with `wr_valid` and `wr_ready` both high. While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and `wr_byte` stays unchanged. Exactly 716 bytes transfer per field.
- R4: The source is read once per payload byte, with `src_idx` running 0 to 523 in ascending order (tags at 0..11, data at 12..523). `src_byte` is sampled in the cycle after the one with `src_rd` high. Reads never occur in consecutive cycles or while `wr_valid` is high.
- R5: The checksums C1, C2 and C3 start at 0, with a carry bit X. For group bytes b0, b1 and b2, the encoder computes, in this order:
  - X = C3 bit 7, then C3 is rotated left by one;
  - w0 = b0 XOR C3, then C1 = C1 + b0 + X, and X takes the carry out;
  - w1 = b1 XOR C1, then C2 = C2 + b1 + X, and X takes the carry;
  - w2 = b2 XOR C2, then C3 = C3 + b2 + X.
- R6: Each group emits the fragment symbol first and then w0[5:0], w1[5:0] and w2[5:0]. The fragment symbol is {w0[7:6], w1[7:6], w2[7:6]}, with w0 in the top bits. Symbol s is sent as the s-th byte, counting from 0 in ascending value, among bytes that have bit 7 set, hold at least one pair of adjacent ones in bits 6..0, hold at most one pair of adjacent zeros, and are neither D5 nor AA. Symbol 0 is 96, and symbol 63 is FF.
- R7: The final group holds only two bytes (524 = 3×174 + 2). Its fragment symbol uses 0 for the missing w2, only three symbols are emitted, and C3 does not take the missing byte.
- R8: After the payload come the symbols {C1[7:6], C2[7:6], C3[7:6]}, then C1[5:0], C2[5:0] and C3[5:0].
- R9: The field ends with the trailer DE AA FF FF.
- R10: `done` is a one-cycle pulse two cycles after the edge that accepts the last trailer byte. `wr_err` then equals `wr_underrun` as sampled in the cycle after that acceptance. `wr_err` holds until the next `start`.
- R11: A `start` pulse while a field is in progress is ignored. The stream and the reads proceed unchanged, and no new field begins after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins one sector field |
| src_rd | output | 1 | Source byte request |
| src_idx | output | 10 | Payload byte index (tags first) |
| src_byte | input | 8 | Source byte, valid the cycle after the request |
| wr_valid | output | 1 | Output byte offered |
| wr_ready | input | 1 | Serializer accepts the offered byte |
| wr_byte | output | 8 | Disk byte |
| wr_underrun | input | 1 | Serializer underrun status |
| done | output | 1 | Field complete pulse |
| wr_err | output | 1 | Write-underrun error from the last field |

## Verification
A prefix byte is offered as soon as SYNC is entered. A group's first symbol appears two cycles after the edge that accepts its last source byte, because FETCH and then LOAD come before GROUP. `done` follows the last trailer acceptance by exactly two edges.

The bench captures every accepted byte at the falling edge, while `wr_valid` and `wr_ready` are stable. It records every read at the falling edge of the request cycle and presents the requested byte at once, so the data is valid in the LOAD cycle. It polls `done` at falling edges and checks `wr_err` in that same sample. Because comparisons are made on the captured stream and not on cycle counts, stalls driven by `wr_ready` do not disturb them. The hold rule during stalls is covered cycle by cycle in the checker.

// File: rtl/gcr_enc_pkg.sv
package gcr_enc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_FETCH,
        ST_LOAD,
        ST_GROUP,
        ST_CKSUM,
        ST_TRAIL,
        ST_FINISH
    } enc_state_t;

    typedef logic [63:0][7:0] sym_table_t;

    localparam int PREFIX_LEN  = 9;
    localparam int TRAILER_LEN = 4;
    localparam logic [5:0] PREFIX_TAIL_SYM = 6'h0B;

    // A disk byte is legal when its top bit is set, some pair of
    // neighbouring low bits are both one, at most one pair are both zero,
    // and it is not one of the two reserved marker values.
    function automatic logic code_legal(input logic [7:0] b);
        int ones;
        int zeros;
        ones  = 0;
        zeros = 0;
        for (int i = 0; i < 6; i++) begin
            if (b[i] && b[i+1])   ones++;
            if (!b[i] && !b[i+1]) zeros++;
        end
        return b[7] && (ones > 0) && (zeros <= 1) &&
               (b != 8'hD5) && (b != 8'hAA);
    endfunction

    function automatic sym_table_t build_table();
        sym_table_t t;
        int n;
        t = '0;
        n = 0;
        for (int v = 128; v < 256; v++) begin
            if (code_legal(8'(v)) && n < 64) begin
                t[n] = 8'(v);
                n++;
            end
        end
        return t;
    endfunction

    function automatic logic [7:0] prefix_byte(input logic [3:0] i);
        case (i)
            4'd0:    return 8'hFF;
            4'd1:    return 8'h3F;
            4'd2:    return 8'hCF;
            4'd3:    return 8'hF3;
            4'd4:    return 8'hFC;
            4'd5:    return 8'hFF;
            4'd6:    return 8'hD5;
            default: return 8'hAA;
        endcase
    endfunction

    function automatic logic [7:0] trailer_byte(input logic [3:0] i);
        case (i)
            4'd0:    return 8'hDE;
            4'd1:    return 8'hAA;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/gcr_sym_lut.sv
module gcr_sym_lut
    import gcr_enc_pkg::*;
(
    input  logic [5:0] sym,
    output logic [7:0] code
);
    localparam sym_table_t TABLE = build_table();

    assign code = TABLE[sym];
endmodule

// File: rtl/gcr_chain.sv
module gcr_chain (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       load,
    input  logic [1:0] pos,
    input  logic [7:0] din,
    output logic [7:0] wout,
    output logic [7:0] c1,
    output logic [7:0] c2,
    output logic [7:0] c3
);
    logic       cy;
    logic [8:0] sum;
    logic [7:0] c3_rot;

    assign c3_rot = {c3[6:0], c3[7]};

    always_comb begin
        unique case (pos)
            2'd0: begin
                wout = din ^ c3_rot;
                sum  = {1'b0, c1} + {1'b0, din} + {8'd0, c3[7]};
            end
            2'd1: begin
                wout = din ^ c1;
                sum  = {1'b0, c2} + {1'b0, din} + {8'd0, cy};
            end
            default: begin
                wout = din ^ c2;
                sum  = {1'b0, c3} + {1'b0, din} + {8'd0, cy};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            c1 <= '0;
            c2 <= '0;
            c3 <= '0;
            cy <= 1'b0;
        end else if (load) begin
            unique case (pos)
                2'd0: begin
                    c3 <= c3_rot;
                    c1 <= sum[7:0];
                    cy <= sum[8];
                end
                2'd1: begin
                    c2 <= sum[7:0];
                    cy <= sum[8];
                end
                default: begin
                    c3 <= sum[7:0];
                    cy <= sum[8];
                end
            endcase
        end
    end
endmodule

// File: rtl/gcr_sector_encoder.sv
module gcr_sector_encoder
    import gcr_enc_pkg::*;
#(
    parameter int TAG_BYTES  = 12,
    parameter int DATA_BYTES = 512,
    parameter int IDXW       = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            src_rd,
    output logic [IDXW-1:0] src_idx,
    input  logic [7:0]      src_byte,
    output logic            wr_valid,
    input  logic            wr_ready,
    output logic [7:0]      wr_byte,
    input  logic            wr_underrun,
    output logic            done,
    output logic            wr_err
);
    localparam int TOTAL = TAG_BYTES + DATA_BYTES;
    localparam logic [IDXW-1:0] TOTAL_V = IDXW'(TOTAL);

    enc_state_t state, nxt;

    logic [IDXW-1:0] idx;
    logic [IDXW-1:0] rem;
    logic [1:0]      gsz;
    logic [1:0]      k;
    logic [1:0]      grp_n;
    logic [1:0]      sym_cnt;
    logic [3:0]      pcnt;
    logic [2:0][7:0] wb;
    logic            done_q;
    logic            err_q;

    logic [7:0] wout, c1, c2, c3;
    logic [5:0] sym;
    logic [7:0] code;
    logic       fire;
    logic       more_in_group;
    logic       grp_last_sym;

    assign rem           = TOTAL_V - idx;
    assign gsz           = (rem >= IDXW'(3)) ? 2'd3 : rem[1:0];
    assign fire          = wr_valid && wr_ready;
    assign more_in_group = ({1'b0, k} + 3'd1) < {1'b0, grp_n};
    assign grp_last_sym  = (sym_cnt == grp_n);

    gcr_chain u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_IDLE && start),
        .load  (state == ST_LOAD),
        .pos   (k),
        .din   (src_byte),
        .wout  (wout),
        .c1    (c1),
        .c2    (c2),
        .c3    (c3)
    );

    gcr_sym_lut u_lut (
        .sym  (sym),
        .code (code)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_SYNC;
            ST_SYNC:   if (wr_ready && pcnt == 4'(PREFIX_LEN - 1)) nxt = ST_FETCH;
            ST_FETCH:  nxt = ST_LOAD;
            ST_LOAD:   nxt = more_in_group ? ST_FETCH : ST_GROUP;
            ST_GROUP:  if (wr_ready && grp_last_sym)
                           nxt = (idx == TOTAL_V) ? ST_CKSUM : ST_FETCH;
            ST_CKSUM:  if (wr_ready && sym_cnt == 2'd3) nxt = ST_TRAIL;
            ST_TRAIL:  if (wr_ready && pcnt == 4'(TRAILER_LEN - 1)) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            k       <= '0;
            grp_n   <= '0;
            sym_cnt <= '0;
            pcnt    <= '0;
            wb      <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= (state == ST_FINISH);
            unique case (state)
                ST_IDLE: if (start) begin
                    idx     <= '0;
                    pcnt    <= '0;
                    k       <= '0;
                    sym_cnt <= '0;
                    err_q   <= 1'b0;
                end
                ST_SYNC: if (fire) pcnt <= pcnt + 4'd1;
                ST_FETCH: begin
                    idx <= idx + IDXW'(1);
                    if (k == 2'd0) begin
                        grp_n <= gsz;
                        wb    <= '0;
                    end
                end
                ST_LOAD: begin
                    wb[k] <= wout;
                    if (more_in_group) k <= k + 2'd1;
                    else               sym_cnt <= 2'd0;
                end
                ST_GROUP: if (fire) begin
                    if (grp_last_sym) begin
                        sym_cnt <= 2'd0;
                        k       <= 2'd0;
                    end else begin
                        sym_cnt <= sym_cnt + 2'd1;
                    end
                end
                ST_CKSUM: if (fire) begin
                    if (sym_cnt == 2'd3) pcnt <= '0;
                    else                 sym_cnt <= sym_cnt + 2'd1;
                end
                ST_TRAIL:  if (fire) pcnt <= pcnt + 4'd1;
                ST_FINISH: err_q <= wr_underrun;
                default: ;
            endcase
        end
    end

    // Output logic
    always_comb begin
        sym      = 6'd0;
        wr_byte  = 8'h00;
        wr_valid = 1'b0;
        src_rd   = 1'b0;
        unique case (state)
            ST_SYNC: begin
                wr_valid = 1'b1;
                sym      = PREFIX_TAIL_SYM;
                wr_byte  = (pcnt == 4'(PREFIX_LEN - 1)) ? code : prefix_byte(pcnt);
            end
            ST_FETCH: src_rd = 1'b1;
            ST_GROUP: begin
                wr_valid = 1'b1;
                sym      = (sym_cnt == 2'd0) ? {wb[0][7:6], wb[1][7:6], wb[2][7:6]}
                                             : wb[sym_cnt - 2'd1][5:0];
                wr_byte  = code;
            end
            ST_CKSUM: begin
                wr_valid = 1'b1;
                unique case (sym_cnt)
                    2'd0:    sym = {c1[7:6], c2[7:6], c3[7:6]};
                    2'd1:    sym = c1[5:0];
                    2'd2:    sym = c2[5:0];
                    default: sym = c3[5:0];
                endcase
                wr_byte = code;
            end
            ST_TRAIL: begin
                wr_valid = 1'b1;
                wr_byte  = trailer_byte(pcnt);
            end
            default: ;
        endcase
    end

    assign src_idx = idx;
    assign done    = done_q;
    assign wr_err  = err_q;
endmodule

// File: rtl/gcr_sector_encoder_chk.sv
module gcr_sector_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       src_rd,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic [7:0] wr_byte,
    input logic       done
);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_byte))
        else $error("R3 offered byte not held");

    p_rd_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd |=> !src_rd)
        else $error("R4 back-to-back reads");

    p_rd_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd |-> !wr_valid)
        else $error("R4 read while offering");

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("R10 done longer than one cycle");

    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_valid && !src_rd)
        else $error("R1 activity at done");
endmodule

bind gcr_sector_encoder gcr_sector_encoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_rd   (src_rd),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_byte  (wr_byte),
    .done     (done)
);

// File: tb/gcr_sector_encoder_bench.sv
module gcr_sector_encoder_bench;
    localparam int NBYTES = 524;
    localparam int NOUT   = 716;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       src_rd;
    logic [9:0] src_idx;
    logic [7:0] src_byte = 8'h00;
    logic       wr_valid;
    logic       wr_ready = 1'b0;
    logic [7:0] wr_byte;
    logic       wr_underrun = 1'b0;
    logic       done;
    logic       wr_err;

    always #5 clk = ~clk;

    gcr_sector_encoder u_gcr_sector_encoder (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_rd(src_rd), .src_idx(src_idx), .src_byte(src_byte),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_byte(wr_byte),
        .wr_underrun(wr_underrun), .done(done), .wr_err(wr_err)
    );

    int tests = 0;
    int fails = 0;
    int ready_mode = 0;
    int cyc = 0;
    int mem [NBYTES];
    int expv [NOUT];
    int got [1024];
    int got_n = 0;
    int rd_n = 0;
    int rd_bad = 0;

    int lut [64] = '{
        8'h96, 8'h97, 8'h9A, 8'h9B, 8'h9D, 8'h9E, 8'h9F, 8'hA6,
        8'hA7, 8'hAB, 8'hAC, 8'hAD, 8'hAE, 8'hAF, 8'hB2, 8'hB3,
        8'hB4, 8'hB5, 8'hB6, 8'hB7, 8'hB9, 8'hBA, 8'hBB, 8'hBC,
        8'hBD, 8'hBE, 8'hBF, 8'hCB, 8'hCD, 8'hCE, 8'hCF, 8'hD3,
        8'hD6, 8'hD7, 8'hD9, 8'hDA, 8'hDB, 8'hDC, 8'hDD, 8'hDE,
        8'hDF, 8'hE5, 8'hE6, 8'hE7, 8'hE9, 8'hEA, 8'hEB, 8'hEC,
        8'hED, 8'hEE, 8'hEF, 8'hF2, 8'hF3, 8'hF4, 8'hF5, 8'hF6,
        8'hF7, 8'hF9, 8'hFA, 8'hFB, 8'hFC, 8'hFD, 8'hFE, 8'hFF};

    // ready pattern driver
    initial forever begin
        @(posedge clk);
        #1;
        cyc++;
        case (ready_mode)
            0:       wr_ready = 1'b1;
            1:       wr_ready = cyc[0];
            default: wr_ready = (cyc % 8) >= 5;
        endcase
    end

    // capture accepted bytes and reads, serve the source
    initial forever begin
        @(negedge clk);
        if (wr_valid && wr_ready && got_n < 1024) begin
            got[got_n] = int'(wr_byte);
            got_n++;
        end
        if (src_rd) begin
            if (int'(src_idx) != rd_n) rd_bad++;
            src_byte = (int'(src_idx) < NBYTES) ? 8'(mem[int'(src_idx)]) : 8'h00;
            rd_n++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp_v);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
        end
    endtask

    task automatic fill_mem(input int pat);
        for (int i = 0; i < NBYTES; i++) begin
            case (pat)
                0:       mem[i] = (i * 7 + 3) & 255;
                1:       mem[i] = 0;
                2:       mem[i] = ((i * 37) ^ (i >> 3) ^ 8'h5A) & 255;
                default: mem[i] = 255;
            endcase
        end
    endtask

    task automatic build_exp();
        int c1, c2, c3, cy, n, s, g, x;
        int b [3];
        int w [3];
        int pre [8] = '{8'hFF, 8'h3F, 8'hCF, 8'hF3, 8'hFC, 8'hFF, 8'hD5, 8'hAA};
        c1 = 0; c2 = 0; c3 = 0; cy = 0; n = 0;
        for (int i = 0; i < 8; i++) begin expv[n] = pre[i]; n++; end
        expv[n] = lut[11]; n++;
        for (int base = 0; base < NBYTES; base += 3) begin
            g = (NBYTES - base >= 3) ? 3 : NBYTES - base;
            w[0] = 0; w[1] = 0; w[2] = 0;
            for (int j = 0; j < g; j++) b[j] = mem[base + j];
            x  = c3 >> 7;
            c3 = ((c3 << 1) | x) & 255;
            w[0] = b[0] ^ c3;
            s = c1 + b[0] + x; c1 = s & 255; cy = s >> 8;
            if (g > 1) begin
                w[1] = b[1] ^ c1;
                s = c2 + b[1] + cy; c2 = s & 255; cy = s >> 8;
            end
            if (g > 2) begin
                w[2] = b[2] ^ c2;
                s = c3 + b[2] + cy; c3 = s & 255; cy = s >> 8;
            end
            expv[n] = lut[((w[0] >> 6) << 4) | ((w[1] >> 6) << 2) | (w[2] >> 6)]; n++;
            for (int j = 0; j < g; j++) begin expv[n] = lut[w[j] & 63]; n++; end
        end
        expv[n] = lut[((c1 >> 6) << 4) | ((c2 >> 6) << 2) | (c3 >> 6)]; n++;
        expv[n] = lut[c1 & 63]; n++;
        expv[n] = lut[c2 & 63]; n++;
        expv[n] = lut[c3 & 63]; n++;
        expv[n] = 8'hDE; n++;
        expv[n] = 8'hAA; n++;
        expv[n] = 8'hFF; n++;
        expv[n] = 8'hFF;
    endtask

    task automatic cmp_range(input int lo, input int hi, input string req, input string what);
        int bad;
        bad = -1;
        for (int i = lo; i <= hi; i++)
            if (bad < 0 && got[i] != expv[i]) bad = i;
        if (bad < 0) check(1'b1, req, what, 0, 0);
        else check(1'b0, req, $sformatf("%s byte %0d", what, bad), got[bad], expv[bad]);
    endtask

    task automatic run_sector(input string name, input int pat, input int rmode,
                              input bit ur, input bit poke);
        int t;
        bit seen;
        fill_mem(pat);
        build_exp();
        got_n = 0; rd_n = 0; rd_bad = 0;
        ready_mode  = rmode;
        wr_underrun = ur;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (60) @(negedge clk);
            start = 1'b1;            // R11: must be ignored
            @(negedge clk); start = 1'b0;
        end
        seen = 1'b0; t = 0;
        while (!seen && t < 20000) begin
            @(negedge clk);
            t++;
            if (done) seen = 1'b1;
        end
        check(seen, "R10", {name, " done pulse"}, int'(seen), 1);
        check(wr_err == ur, "R10", {name, " underrun error"}, int'(wr_err), int'(ur));
        check(got_n == NOUT, "R3", {name, " accepted byte count"}, got_n, NOUT);
        check(rd_n == NBYTES && rd_bad == 0, "R4", {name, " read order/count"}, rd_n, NBYTES);
        if (got_n == NOUT) begin
            cmp_range(0, 8, "R2", {name, " prefix"});
            cmp_range(9, 704, "R5", {name, " whitened groups (R6 codes)"});
            cmp_range(705, 707, "R7", {name, " short final group"});
            cmp_range(708, 711, "R8", {name, " checksum field"});
            cmp_range(712, 715, "R9", {name, " trailer"});
        end
        // R1/R11: nothing further happens after done
        t = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (wr_valid || src_rd || done) t++;
        end
        check(t == 0, "R11", {name, " idle after done"}, t, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!wr_valid && !src_rd && !done, "R1", "outputs in reset",
              {29'd0, wr_valid, src_rd, done}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!wr_valid && !src_rd && !done && !wr_err, "R1", "idle after reset",
              {29'd0, wr_valid, src_rd, done}, 0);
        run_sector("ramp", 0, 0, 1'b0, 1'b0);
        run_sector("zeros", 1, 1, 1'b0, 1'b0);
        run_sector("mixed", 2, 2, 1'b1, 1'b1);
        run_sector("ones", 3, 0, 1'b0, 1'b0);
        check(lut[0] == 8'h96 && lut[63] == 8'hFF, "R6", "table ends", lut[0], 8'h96);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule